// File: doc/BRIEF.md
# Strobed Input Port with Read Handshake

This block is the receive side of a byte-wide parallel port. A peripheral places a byte on `pdata` and pulses the active-low strobe `stb_n`. The block takes the byte into a holding register, raises a buffer-full flag `ibf` toward the peripheral, and can raise an interrupt request `intr` toward the host. The host reads with the active-low `rd_n`. The held byte is always on `rdata`. Ending the read clears the full flag.

The strobe and the read arrive without a fixed relation to the system clock. Each one passes through a synchronizer of `SYNC_STAGES` flops. After that, edge detection runs on the one clock. Each flag follows one edge of one signal:

- The falling edge of the strobe sets `ibf`.
- The rising edge of the strobe captures the byte and may raise `intr`.
- The falling edge of the read drops `intr`.
- The rising edge of the read clears `ibf`.

There is no back-pressure toward the peripheral. `ibf` is advisory only. A strobe that comes while the buffer is still full replaces the held byte, and the loss is recorded on a sticky `overrun`. The host side has no stall either. A read with nothing held returns the old byte and changes no flag. A single interrupt-enable bit is written through `ie_we`/`ie_d`. It is the only programmable state.

Top module: `strobed_in_port`

## Requirements
- R1: A synchronous active-high `rst` clears `rdata` to 0, clears `ibf`, `intr` and `overrun`, and clears the interrupt enable. After a reset, a transfer does not raise `intr` until the enable is written again.
- R2: A falling edge on `stb_n` sets `ibf`. The change is visible after the third rising clock edge that follows the input change (SYNC_STAGES+1 with the default of 2), and not before.
- R3: `rdata` takes the value that `pdata` holds at the rising edge of `stb_n`, not the value it held at the falling edge. The new byte is visible after the third clock edge following the rise. `pdata` must stay stable until then, and later changes of `pdata` do not alter `rdata`.
- R4: A rising edge on `stb_n` asserts `intr` when the enable is 1 and `ibf` stays set. With the enable at 0, `intr` stays low through a complete transfer.
- R5: A falling edge on `rd_n` deasserts `intr`, visible after the third clock edge. This clear wins over a strobe rise in the same cycle.
- R6: A rising edge on `rd_n` clears `ibf`, visible after the third clock edge. `intr` is never high unless both `ibf` and the enable are 1.
- R7: A complete read while `ibf` is 0 leaves `rdata`, `ibf`, `intr` and `overrun` unchanged.
- R8: A falling edge on `stb_n` while `ibf` is 1, with no read rise in the same cycle, sets `overrun`. The following strobe rise overwrites the held byte. `overrun` stays set until reset, including across reads.
- R9: When a strobe fall and a read rise are detected in the same cycle, `ibf` ends up 1 and `overrun` stays 0.
- R10: With `ie_we` high at a clock edge, the enable takes `ie_d`. Writing 0 drops a pending `intr` at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pdata | input | DATA_W | Peripheral data byte |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| rd_n | input | 1 | Host read, active low, asynchronous |
| ie_we | input | 1 | Write strobe for the interrupt enable |
| ie_d | input | 1 | New interrupt-enable value |
| rdata | output | DATA_W | Held byte toward the host |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request to the host |
| overrun | output | 1 | Sticky flag: a held byte was overwritten before it was read |

## Verification
The function that most often overlaps another is the one where the end of a host read clears the full flag while a new strobe sets it. The bench forces this case by releasing `rd_n` and pulling `stb_n` low on the same clock edge, with the buffer full. Both inputs pass through synchronizers of equal depth, so their edges are detected in the same cycle. The bench then expects `ibf` to stay 1 and `overrun` to stay 0, and it expects the next read to return the new byte. A second overlap comes from writing the enable to 0 while `intr` is high; the request is expected to drop after one clock edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // one-cycle pulses produced by an edge detector
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // channel indices for the synchronized control inputs
  localparam int CH_STB = 0;
  localparam int CH_RD  = 1;
  localparam int N_CH   = 2;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sp_edge.sv
module sp_edge
  import sp_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  lvl,
  output edge_t ev
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= lvl;
  end

  assign ev.rise = ~prev & lvl;
  assign ev.fall = prev & ~lvl;
endmodule

// File: rtl/sp_flags.sv
module sp_flags
  import sp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  edge_t stb_ev,
  input  edge_t rd_ev,
  input  logic  ie_we,
  input  logic  ie_d,
  output logic  ibf,
  output logic  intr,
  output logic  overrun,
  output logic  ie_q,
  output logic  capture
);
  logic ie_nx, ibf_nx, ovr_nx, intr_nx;

  always_comb begin
    ie_nx = ie_we ? ie_d : ie_q;
    // a new strobe outranks the end of a read
    if (stb_ev.fall)     ibf_nx = 1'b1;
    else if (rd_ev.rise) ibf_nx = 1'b0;
    else                 ibf_nx = ibf;
    ovr_nx = overrun | (stb_ev.fall & ibf & ~rd_ev.rise);
    // request needs enable and a full buffer in the next state
    if (rd_ev.fall || !ie_nx || !ibf_nx) intr_nx = 1'b0;
    else if (stb_ev.rise)                intr_nx = 1'b1;
    else                                 intr_nx = intr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      ibf     <= 1'b0;
      intr    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ie_q    <= ie_nx;
      ibf     <= ibf_nx;
      intr    <= intr_nx;
      overrun <= ovr_nx;
    end
  end

  assign capture = stb_ev.rise;
endmodule

// File: rtl/sp_latch.sv
module sp_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (cap) dout <= din;
  end
endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
  import sp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pdata,
  input  logic              stb_n,
  input  logic              rd_n,
  input  logic              ie_we,
  input  logic              ie_d,
  output logic [DATA_W-1:0] rdata,
  output logic              ibf,
  output logic              intr,
  output logic              overrun
);
  logic [N_CH-1:0] raw;
  logic [N_CH-1:0] synced;
  edge_t           ev [N_CH];
  edge_t           stb_ev, rd_ev;
  logic            ie_q;
  logic            capture;

  assign raw[CH_STB] = stb_n;
  assign raw[CH_RD]  = rd_n;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    sp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(raw[c]), .q(synced[c])
    );
    sp_edge #(.IDLE(1'b1)) u_edge (
      .clk(clk), .rst(rst), .lvl(synced[c]), .ev(ev[c])
    );
  end

  assign stb_ev = ev[CH_STB];
  assign rd_ev  = ev[CH_RD];

  sp_flags u_flags (
    .clk(clk), .rst(rst), .stb_ev(stb_ev), .rd_ev(rd_ev),
    .ie_we(ie_we), .ie_d(ie_d), .ibf(ibf), .intr(intr),
    .overrun(overrun), .ie_q(ie_q), .capture(capture)
  );

  sp_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .cap(capture), .din(pdata), .dout(rdata)
  );
endmodule

// File: rtl/strobed_in_port_chk.sv
module strobed_in_port_chk
  import sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] pdata,
  input logic [DATA_W-1:0] rdata,
  input logic              ibf,
  input logic              intr,
  input logic              overrun,
  input logic              ie_q,
  input edge_t             stb_ev,
  input edge_t             rd_ev
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!ibf && !intr && !overrun && !ie_q && rdata == '0));

  assert_fall_sets_full_R2: assert property (@(posedge clk) disable iff (rst)
    stb_ev.fall |=> ibf);

  assert_capture_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    stb_ev.rise |=> rdata == $past(pdata));

  assert_read_drops_intr_R5: assert property (@(posedge clk) disable iff (rst)
    rd_ev.fall |=> !intr);

  assert_read_end_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_ev.rise && !stb_ev.fall) |=> !ibf);

  assert_intr_needs_full_R6: assert property (@(posedge clk) disable iff (rst)
    intr |-> (ibf && ie_q));

  assert_data_held_R7: assert property (@(posedge clk) disable iff (rst)
    !stb_ev.rise |=> $stable(rdata));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_same_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (stb_ev.fall && rd_ev.rise) |=> (ibf && overrun == $past(overrun)));
endmodule

bind strobed_in_port strobed_in_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .pdata(pdata), .rdata(rdata), .ibf(ibf),
  .intr(intr), .overrun(overrun), .ie_q(ie_q),
  .stb_ev(stb_ev), .rd_ev(rd_ev)
);

// File: tb/tb_strobed_in_port.sv
module tb_strobed_in_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pdata = 8'h00;
  logic       stb_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       ie_we = 1'b0;
  logic       ie_d = 1'b0;
  logic [7:0] rdata;
  logic       ibf, intr, overrun;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_rd = 8'h00;
  logic       mdl_full = 1'b0;
  bit         done = 1'b0;
  event       sample_ev;

  always #10 clk = ~clk;

  strobed_in_port dut (
    .clk(clk), .rst(rst), .pdata(pdata), .stb_n(stb_n), .rd_n(rd_n),
    .ie_we(ie_we), .ie_d(ie_d), .rdata(rdata), .ibf(ibf),
    .intr(intr), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one peripheral transfer; the byte is valid only near the rise
  task automatic strobe_byte(input logic [7:0] b);
    pdata = ~b;
    stb_n = 1'b0;
    wait_n(2);
    pdata = b;
    wait_n(2);
    stb_n = 1'b1;
    wait_n(4);
    pdata = ~b;
    if (mdl_full) void'(exp_q.pop_back());
    exp_q.push_back(b);
    mdl_full = 1'b1;
  endtask

  task automatic host_read();
    rd_n = 1'b0;
    wait_n(3);
    chk(intr == 1'b0, "R5 intr after read fall", intr, 0);
    ->sample_ev;
    wait_n(1);
    rd_n = 1'b1;
    wait_n(3);
    chk(ibf == 1'b0, "R6 ibf after read rise", ibf, 0);
    mdl_full = 1'b0;
  endtask

  task automatic write_ie(input logic v);
    ie_d = v;
    ie_we = 1'b1;
    wait_n(1);
    ie_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    exp_q.delete();
    mdl_full = 1'b0;
    last_rd = 8'h00;
    wait_n(1);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rdata == e, "R3 read data", rdata, e);
        last_rd = e;
      end else begin
        chk(rdata == last_rd, "R7 empty read data", rdata, last_rd);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    chk(rdata == 8'h00 && !ibf && !intr && !overrun, "R1 reset state",
        {rdata, ibf, intr, overrun}, 0);

    // R7 read with nothing held
    host_read();
    chk(!ibf && !intr && !overrun, "R7 flags after empty read",
        {ibf, intr, overrun}, 0);

    // R2 latency, R4 no intr with enable low
    pdata = 8'h5A;
    stb_n = 1'b0;
    wait_n(2);
    chk(ibf == 1'b0, "R2 ibf not yet set", ibf, 0);
    wait_n(1);
    chk(ibf == 1'b1, "R2 ibf set on third edge", ibf, 1);
    pdata = 8'hA5;
    wait_n(1);
    stb_n = 1'b1;
    wait_n(3);
    chk(rdata == 8'hA5, "R3 byte taken at strobe rise", rdata, 8'hA5);
    chk(intr == 1'b0, "R4 intr stays low with enable 0", intr, 0);
    pdata = 8'h00;
    wait_n(2);
    chk(rdata == 8'hA5, "R3 later pdata ignored", rdata, 8'hA5);
    exp_q.push_back(8'hA5);
    mdl_full = 1'b1;
    host_read();

    // R4 intr with enable, R5/R6 by read
    write_ie(1'b1);
    strobe_byte(8'h3C);
    chk(intr == 1'b1, "R4 intr after strobe rise", intr, 1);
    host_read();
    chk(intr == 1'b0, "R6 intr low after read", intr, 0);

    // R8 overrun
    strobe_byte(8'h11);
    chk(overrun == 1'b0, "R8 no overrun on first byte", overrun, 0);
    strobe_byte(8'h22);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    host_read();
    chk(overrun == 1'b1, "R8 overrun sticky after read", overrun, 1);
    do_reset();
    chk(overrun == 1'b0 && rdata == 8'h00, "R1 reset clears overrun",
        {rdata, overrun}, 0);

    // R10 enable write of 0 drops intr
    write_ie(1'b1);
    strobe_byte(8'h5A);
    chk(intr == 1'b1, "R10 intr pending", intr, 1);
    write_ie(1'b0);
    chk(intr == 1'b0, "R10 intr dropped by enable 0", intr, 0);
    host_read();

    // R9 strobe fall and read rise in the same cycle
    strobe_byte(8'h77);
    rd_n = 1'b0;
    wait_n(4);
    ->sample_ev;
    wait_n(1);
    rd_n = 1'b1;
    stb_n = 1'b0;
    pdata = 8'h88;
    mdl_full = 1'b0;
    wait_n(3);
    chk(ibf == 1'b1, "R9 ibf stays set", ibf, 1);
    chk(overrun == 1'b0, "R9 no overrun", overrun, 0);
    wait_n(1);
    stb_n = 1'b1;
    wait_n(4);
    exp_q.push_back(8'h88);
    mdl_full = 1'b1;
    host_read();

    // R1 reset clears the enable
    write_ie(1'b1);
    do_reset();
    strobe_byte(8'hC3);
    chk(intr == 1'b0, "R1 enable cleared by reset", intr, 0);
    host_read();

    wait_n(2);
    finish_run();
  end
endmodule